// File: doc/BRIEF.md
# MAC Register Bring-Up Sequencer

This block configures a network MAC through the MAC's memory-mapped register port after reset, so that no processor has to take part. On a rising edge of its start input it runs a fixed sequence of four bus transfers. First it reads the identification register at word offset 0 and keeps that value. Next it reads the command/configuration register at word offset 2, sets the transmit-enable and receive-enable bits, and writes the value back. Finally it reads that register a second time to confirm that both enables have stayed set.

The bus is a word-addressed register port. The slave can stall any transfer for a variable number of cycles by raising waitrequest. A transfer takes effect on the clock edge where its command is high and waitrequest is low. For a read, the data arrives one cycle after that edge. A stall counter ends any transfer that stays stalled for too long. The run ends with either done or error held high until the next start.

Top module: `mac_cfg_boot`

## Requirements
- R1: During and right after reset, bus_rd, bus_wr, done and error are low and rev_value is zero.
- R2: While a command (bus_rd or bus_wr) is high and bus_wait is high, the next cycle keeps the same command, bus_addr and bus_wdata. The one exception is the abort in R8.
- R3: A transfer is accepted on the edge where its command is high and bus_wait is low. The command is low in the cycle after that edge.
- R4: Read data is taken from bus_rdata on the clock edge one cycle after the read was accepted. Data present in any other cycle is not used.
- R5: A run makes its accesses in this order: read of word 0, read of word 2, write of word 2, read of word 2. The write data is the first word-2 read value with bit 0 (transmit enable) and bit 1 (receive enable) set and every other bit unchanged.
- R6: rev_value holds the data returned by the word-0 read of the latest run that got that far.
- R7: If the final read returns bits 0 and 1 both set, done goes high. Otherwise error goes high. done and error are never high together.
- R8: A stall of up to 256 cycles on one access is tolerated. On the 257th consecutive stalled cycle the command is dropped, error goes high, and no further access is made.
- R9: Only a low-to-high transition of start begins a run. Holding start high does not start another run, and a start edge while a run is in progress has no effect.
- R10: A start edge after done or error clears both outputs and runs the whole sequence again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | A rising edge begins a bring-up run |
| bus_addr | output | 8 | Word address on the register port |
| bus_rd | output | 1 | Read command |
| bus_wr | output | 1 | Write command |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, valid one cycle after a read is accepted |
| bus_wait | input | 1 | Slave stall request |
| done | output | 1 | The run finished and both enables read back set |
| error | output | 1 | The run failed on a timeout or on the read-back check |
| rev_value | output | 32 | Captured identification register |

## Verification
A wrong transfer-engine state shows up at the port within one cycle. The symptom is a command that changes during a stall, a command that lasts past its accept edge, or two commands at once. A sequencer that skips or repeats a step shows up at the next new access, as a wrong address, a wrong direction or wrong write data. Capture at the wrong moment shows up when the run ends: the bench drives junk on bus_rdata in every cycle except the data cycle, so a late or early capture gives a wrong rev_value or a wrong done/error outcome. Stall-counter faults show up either as error on a 256-cycle stall or as a missed abort on 257 stalled cycles.

// File: rtl/mcb_pkg.sv
package mcb_pkg;

   typedef enum logic [1:0] {
      XF_IDLE = 2'd0,
      XF_CMD  = 2'd1,
      XF_DATA = 2'd2
   } xfer_state_t;

   typedef enum logic [2:0] {
      SQ_IDLE   = 3'd0,
      SQ_REV    = 3'd1,
      SQ_CFG_RD = 3'd2,
      SQ_CFG_WR = 3'd3,
      SQ_CHECK  = 3'd4,
      SQ_DONE   = 3'd5,
      SQ_FAIL   = 3'd6
   } seq_state_t;

   function automatic logic seq_busy(input seq_state_t s);
      return (s == SQ_REV) || (s == SQ_CFG_RD) || (s == SQ_CFG_WR) || (s == SQ_CHECK);
   endfunction

endpackage

// File: rtl/mcb_stall_guard.sv
module mcb_stall_guard #(
   parameter int LIMIT = 256
) (
   input  logic clk,
   input  logic rst,
   input  logic active,
   input  logic stalled,
   output logic expired
);
   generate
      if (LIMIT == 0) begin : g_off
         assign expired = 1'b0;
      end else begin : g_on
         localparam int CNT_W = $clog2(LIMIT + 1);
         localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(LIMIT);
         logic [CNT_W-1:0] cnt;

         always_ff @(posedge clk) begin
            if (rst || !active) begin
               cnt <= '0;
            end else if (stalled && cnt != CNT_MAX) begin
               cnt <= cnt + 1'b1;
            end
         end

         assign expired = active && stalled && (cnt == CNT_MAX);

         // R8: the stalled-cycle count never runs past the limit
         p_cnt_bound_r8: assert property (@(posedge clk) disable iff (rst)
            cnt <= CNT_MAX);
         // R8: counting restarts whenever the command is idle
         p_cnt_clear_r8: assert property (@(posedge clk) disable iff (rst)
            !active |=> cnt == '0);
      end
   endgenerate
endmodule

// File: rtl/mcb_mm_master.sv
module mcb_mm_master
   import mcb_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32,
   parameter int STALL_LIMIT = 256
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req_valid,
   input  logic              req_wr,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              fin,
   output logic              fin_tout,
   output logic [DATA_W-1:0] fin_rdata,
   output logic [ADDR_W-1:0] bus_addr,
   output logic              bus_rd,
   output logic              bus_wr,
   output logic [DATA_W-1:0] bus_wdata,
   input  logic [DATA_W-1:0] bus_rdata,
   input  logic              bus_wait
);
   xfer_state_t st;
   logic        cmd_on;
   logic        expired;

   assign cmd_on = bus_rd || bus_wr;

   mcb_stall_guard #(.LIMIT(STALL_LIMIT)) u_guard (
      .clk     (clk),
      .rst     (rst),
      .active  (cmd_on),
      .stalled (bus_wait),
      .expired (expired)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         st        <= XF_IDLE;
         bus_rd    <= 1'b0;
         bus_wr    <= 1'b0;
         bus_addr  <= '0;
         bus_wdata <= '0;
         fin       <= 1'b0;
         fin_tout  <= 1'b0;
         fin_rdata <= '0;
      end else begin
         fin      <= 1'b0;
         fin_tout <= 1'b0;
         unique case (st)
            XF_IDLE: begin
               if (req_valid) begin
                  bus_addr  <= req_addr;
                  bus_wdata <= req_wdata;
                  bus_rd    <= !req_wr;
                  bus_wr    <= req_wr;
                  st        <= XF_CMD;
               end
            end
            XF_CMD: begin
               if (expired) begin
                  bus_rd   <= 1'b0;
                  bus_wr   <= 1'b0;
                  fin      <= 1'b1;
                  fin_tout <= 1'b1;
                  st       <= XF_IDLE;
               end else if (!bus_wait) begin
                  bus_rd <= 1'b0;
                  bus_wr <= 1'b0;
                  if (bus_rd) begin
                     st <= XF_DATA;
                  end else begin
                     fin <= 1'b1;
                     st  <= XF_IDLE;
                  end
               end
            end
            XF_DATA: begin
               fin_rdata <= bus_rdata;
               fin       <= 1'b1;
               st        <= XF_IDLE;
            end
            default: st <= XF_IDLE;
         endcase
      end
   end

   // R2: command, address and data are held through a stall unless aborted
   p_hold_r2: assert property (@(posedge clk) disable iff (rst)
      (cmd_on && bus_wait && !expired) |=>
         ($stable(bus_rd) && $stable(bus_wr) && $stable(bus_addr) && $stable(bus_wdata)));
   // R3: command is dropped right after the accepting edge
   p_drop_r3: assert property (@(posedge clk) disable iff (rst)
      (cmd_on && !bus_wait) |=> !cmd_on);
   // R3: never both directions at once
   p_one_cmd_r3: assert property (@(posedge clk) disable iff (rst)
      !(bus_rd && bus_wr));
   // R4: read data is taken from the bus one cycle after acceptance
   p_capture_r4: assert property (@(posedge clk) disable iff (rst)
      (bus_rd && !bus_wait) |=> ##1 (fin && fin_rdata == $past(bus_rdata)));
   // R8: an expired stall drops the command
   p_abort_r8: assert property (@(posedge clk) disable iff (rst)
      expired |=> (!cmd_on && fin && fin_tout));
endmodule

// File: rtl/mcb_boot_seq.sv
module mcb_boot_seq
   import mcb_pkg::*;
#(
   parameter int ADDR_W   = 8,
   parameter int DATA_W   = 32,
   parameter int REV_ADDR = 0,
   parameter int CFG_ADDR = 2,
   parameter int TX_BIT   = 0,
   parameter int RX_BIT   = 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start_evt,
   output logic              req_valid,
   output logic              req_wr,
   output logic [ADDR_W-1:0] req_addr,
   output logic [DATA_W-1:0] req_wdata,
   input  logic              fin,
   input  logic              fin_tout,
   input  logic [DATA_W-1:0] fin_rdata,
   output logic              done,
   output logic              error,
   output logic [DATA_W-1:0] rev_value
);
   localparam logic [DATA_W-1:0] EN_MASK =
      (DATA_W'(1) << TX_BIT) | (DATA_W'(1) << RX_BIT);
   localparam logic [ADDR_W-1:0] A_REV = ADDR_W'(REV_ADDR);
   localparam logic [ADDR_W-1:0] A_CFG = ADDR_W'(CFG_ADDR);

   seq_state_t        st;
   logic              pending;
   logic [DATA_W-1:0] cfg_new;

   always_comb begin
      req_valid = seq_busy(st) && !pending;
      req_wr    = (st == SQ_CFG_WR);
      req_addr  = (st == SQ_REV) ? A_REV : A_CFG;
      req_wdata = cfg_new;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st        <= SQ_IDLE;
         pending   <= 1'b0;
         cfg_new   <= '0;
         rev_value <= '0;
      end else begin
         if (req_valid) pending <= 1'b1;
         if (!seq_busy(st)) begin
            if (start_evt) begin
               st      <= SQ_REV;
               pending <= 1'b0;
            end
         end else if (fin) begin
            pending <= 1'b0;
            if (fin_tout) begin
               st <= SQ_FAIL;
            end else begin
               unique case (st)
                  SQ_REV: begin
                     rev_value <= fin_rdata;
                     st        <= SQ_CFG_RD;
                  end
                  SQ_CFG_RD: begin
                     cfg_new <= fin_rdata | EN_MASK;
                     st      <= SQ_CFG_WR;
                  end
                  SQ_CFG_WR: st <= SQ_CHECK;
                  SQ_CHECK:  st <= ((fin_rdata & EN_MASK) == EN_MASK) ? SQ_DONE : SQ_FAIL;
                  default:   st <= SQ_FAIL;
               endcase
            end
         end
      end
   end

   assign done  = (st == SQ_DONE);
   assign error = (st == SQ_FAIL);

   // R7: outcome flags are exclusive
   p_outcome_r7: assert property (@(posedge clk) disable iff (rst)
      $onehot0({done, error}));
   // R9: while a run is active only a finished transfer moves the sequence
   p_ignore_start_r9: assert property (@(posedge clk) disable iff (rst)
      (seq_busy(st) && !fin) |=> (st == $past(st)));
   // R8: a timed-out transfer ends the run in error
   p_tout_fail_r8: assert property (@(posedge clk) disable iff (rst)
      (seq_busy(st) && fin && fin_tout) |=> error);
   // R10: a start edge after an outcome clears it
   p_rerun_r10: assert property (@(posedge clk) disable iff (rst)
      ((done || error) && start_evt) |=> (!done && !error));
endmodule

// File: rtl/mac_cfg_boot.sv
module mac_cfg_boot #(
   parameter int ADDR_W      = 8,
   parameter int DATA_W      = 32,
   parameter int REV_ADDR    = 0,
   parameter int CFG_ADDR    = 2,
   parameter int TX_BIT      = 0,
   parameter int RX_BIT      = 1,
   parameter int STALL_LIMIT = 256,
   parameter int START_SYNC  = 0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   output logic [ADDR_W-1:0] bus_addr,
   output logic              bus_rd,
   output logic              bus_wr,
   output logic [DATA_W-1:0] bus_wdata,
   input  logic [DATA_W-1:0] bus_rdata,
   input  logic              bus_wait,
   output logic              done,
   output logic              error,
   output logic [DATA_W-1:0] rev_value
);
   generate
      if (ADDR_W < 2 || ADDR_W > 32) begin : g_bad_addr
         $error("mac_cfg_boot: ADDR_W out of range");
      end
      if (DATA_W < 2) begin : g_bad_data
         $error("mac_cfg_boot: DATA_W too small");
      end
      if (TX_BIT == RX_BIT || TX_BIT >= DATA_W || RX_BIT >= DATA_W) begin : g_bad_bits
         $error("mac_cfg_boot: enable bit positions invalid");
      end
      if (REV_ADDR >= (1 << ADDR_W) || CFG_ADDR >= (1 << ADDR_W)) begin : g_bad_map
         $error("mac_cfg_boot: register offset does not fit address");
      end
      if (STALL_LIMIT < 0 || START_SYNC < 0) begin : g_bad_opt
         $error("mac_cfg_boot: negative option");
      end
   endgenerate

   logic start_s;
   logic start_q;
   logic start_evt;

   generate
      if (START_SYNC == 0) begin : g_direct
         assign start_s = start;
      end else begin : g_sync
         logic [START_SYNC-1:0] sync_r;
         always_ff @(posedge clk) begin
            if (rst) sync_r <= '0;
            else     sync_r <= {sync_r[START_SYNC-2 >= 0 ? START_SYNC-2 : 0 : 0], start};
         end
         assign start_s = sync_r[START_SYNC-1];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) start_q <= 1'b0;
      else     start_q <= start_s;
   end
   assign start_evt = start_s && !start_q;

   logic              req_valid;
   logic              req_wr;
   logic [ADDR_W-1:0] req_addr;
   logic [DATA_W-1:0] req_wdata;
   logic              fin;
   logic              fin_tout;
   logic [DATA_W-1:0] fin_rdata;

   mcb_boot_seq #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REV_ADDR(REV_ADDR),
      .CFG_ADDR(CFG_ADDR), .TX_BIT(TX_BIT), .RX_BIT(RX_BIT)
   ) u_seq (
      .clk       (clk),
      .rst       (rst),
      .start_evt (start_evt),
      .req_valid (req_valid),
      .req_wr    (req_wr),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .fin       (fin),
      .fin_tout  (fin_tout),
      .fin_rdata (fin_rdata),
      .done      (done),
      .error     (error),
      .rev_value (rev_value)
   );

   mcb_mm_master #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STALL_LIMIT(STALL_LIMIT)
   ) u_mst (
      .clk       (clk),
      .rst       (rst),
      .req_valid (req_valid),
      .req_wr    (req_wr),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .fin       (fin),
      .fin_tout  (fin_tout),
      .fin_rdata (fin_rdata),
      .bus_addr  (bus_addr),
      .bus_rd    (bus_rd),
      .bus_wr    (bus_wr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .bus_wait  (bus_wait)
   );

   // R1: idle outputs straight after reset
   p_reset_r1: assert property (@(posedge clk)
      $past(rst) |-> (!bus_rd && !bus_wr && !done && !error));
endmodule

// File: tb/mac_cfg_boot_bench.sv
module mac_cfg_boot_bench;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        start = 1'b0;
   logic [7:0]  bus_addr;
   logic        bus_rd, bus_wr;
   logic [31:0] bus_wdata;
   logic [31:0] bus_rdata = 32'h0;
   logic        bus_wait = 1'b0;
   logic        done, error;
   logic [31:0] rev_value;

   always #5 clk = ~clk;

   mac_cfg_boot u_mac_cfg_boot (
      .clk(clk), .rst(rst), .start(start),
      .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_wait(bus_wait),
      .done(done), .error(error), .rev_value(rev_value)
   );

   int total = 0;
   int bad = 0;
   int cycles = 0;

   // slave model state
   logic [31:0] m_rev, m_cfg, m_keep;
   int          m_stall[4];
   int          acc_n = 0;
   int          stall_left = 0;
   int          stall_now = 0;
   int          aborts = 0;
   logic        p_rd = 0, p_wr = 0, p_wait = 0;
   logic [7:0]  p_addr = 0;
   logic [31:0] p_wdata = 0;
   logic [31:0] exp_wdata = 0;

   task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   // reference slave and per-cycle protocol comparison
   initial begin
      forever begin
         @(negedge clk);
         cycles++;
         if (!rst) begin
            logic cur;
            cur = bus_rd || bus_wr;
            chk(!(done && error), "R7 done/error together", {done, error}, 0);
            chk(!(bus_rd && bus_wr), "R3 both commands", {bus_rd, bus_wr}, 0);
            if ((p_rd || p_wr) && p_wait) begin
               if (!cur) begin
                  aborts++;
                  chk(stall_now > 256, "R8 premature abort", stall_now, 257);
               end else begin
                  chk(bus_rd == p_rd && bus_wr == p_wr, "R2 command changed in stall", {bus_rd, bus_wr}, {p_rd, p_wr});
                  chk(bus_addr == p_addr, "R2 address changed in stall", bus_addr, p_addr);
                  chk(bus_wdata == p_wdata, "R2 wdata changed in stall", bus_wdata, p_wdata);
               end
            end
            if ((p_rd || p_wr) && !p_wait) begin
               chk(!cur, "R3 command held past accept", cur, 0);
               if (p_wr) m_cfg = p_wdata & m_keep;
               if (p_rd) bus_rdata = (p_addr == 8'd0) ? m_rev : m_cfg;
            end else begin
               bus_rdata = 32'h5EED_0000 ^ cycles;
            end
            if (cur && !(p_rd || p_wr)) begin
               // R5: expected order R0, R2, W2, R2
               case (acc_n)
                  0: chk(bus_rd && bus_addr == 8'd0, "R5 first access", {bus_wr, bus_addr}, 9'h000);
                  1: chk(bus_rd && bus_addr == 8'd2, "R5 second access", {bus_wr, bus_addr}, 9'h002);
                  2: begin
                     chk(bus_wr && bus_addr == 8'd2, "R5 third access", {bus_wr, bus_addr}, 9'h102);
                     exp_wdata = m_cfg | 32'h3;
                     chk(bus_wdata == exp_wdata, "R5 write data", bus_wdata, exp_wdata);
                  end
                  3: chk(bus_rd && bus_addr == 8'd2, "R5 fourth access", {bus_wr, bus_addr}, 9'h002);
                  default: chk(0, "R9 extra access", acc_n, 3);
               endcase
               stall_now = m_stall[acc_n < 4 ? acc_n : 3];
               stall_left = stall_now;
               acc_n++;
            end
            bus_wait = cur && (stall_left > 0);
            if (bus_wait) stall_left--;
            p_rd = bus_rd; p_wr = bus_wr; p_wait = bus_wait;
            p_addr = bus_addr; p_wdata = bus_wdata;
         end
      end
   end

   initial begin
      @(posedge clk);
      while (cycles < 150000) @(posedge clk);
      chk(0, "watchdog", cycles, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   task automatic run(input logic [31:0] rev, input logic [31:0] cfg, input logic [31:0] keep,
                      input int s0, input int s1, input int s2, input int s3,
                      input logic hold, input logic mid_pulse,
                      input logic e_done, input int e_acc, input string tag);
      m_rev = rev; m_cfg = cfg; m_keep = keep;
      m_stall[0] = s0; m_stall[1] = s1; m_stall[2] = s2; m_stall[3] = s3;
      acc_n = 0; aborts = 0;
      @(negedge clk); start = 1'b1;
      if (!hold) begin @(negedge clk); start = 1'b0; end
      if (mid_pulse) begin
         repeat (6) @(negedge clk);
         start = 1'b1; @(negedge clk); start = 1'b0;
         @(negedge clk); start = 1'b1; @(negedge clk); start = 1'b0;
      end
      for (int i = 0; i < 5000 && !(done || error); i++) @(negedge clk);
      repeat (40) @(negedge clk);
      start = 1'b0;
      chk(done == e_done, {tag, " done"}, done, e_done);
      chk(error == !e_done, {tag, " error"}, error, !e_done);
      chk(acc_n == e_acc, {tag, " access count"}, acc_n, e_acc);
      if (e_acc >= 2) chk(rev_value == rev, {"R6 ", tag, " revision"}, rev_value, rev);
      repeat (3) @(negedge clk);
   endtask

   initial begin
      m_stall[0] = 0; m_stall[1] = 0; m_stall[2] = 0; m_stall[3] = 0;
      m_keep = '1; m_rev = 0; m_cfg = 0;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(!bus_rd && !bus_wr && !done && !error && rev_value == 0, "R1 reset state",
          {bus_rd, bus_wr, done, error}, 0);
      rst = 1'b0;
      @(negedge clk);
      chk(!bus_rd && !bus_wr && !done && !error && rev_value == 0, "R1 after reset",
          {bus_rd, bus_wr, done, error}, 0);
      // R5 R6 R7 R9: no stall, start held high must not rerun
      run(32'hA5A5_0107, 32'h1234_5670, '1, 0, 0, 0, 0, 1'b1, 1'b0, 1'b1, 4, "R9 held start");
      // R10 rerun after done; R2 R3 R4 variable stall; R9 pulse mid-run ignored
      run(32'h0BAD_CAFE, 32'hFFFF_FF00, '1, 3, 1, 5, 2, 1'b0, 1'b1, 1'b1, 4, "R10 rerun/R9 mid pulse");
      // R7 read-back failure: receive enable cannot be set
      run(32'h0000_0042, 32'h0000_0010, 32'hFFFF_FFFD, 2, 0, 1, 3, 1'b0, 1'b0, 1'b0, 4, "R7 stuck enable");
      // R8 longest tolerated stall
      run(32'h1111_2222, 32'h8000_0001, '1, 256, 4, 256, 0, 1'b0, 1'b0, 1'b1, 4, "R8 stall 256");
      // R8 timeout on first access
      run(32'h3333_4444, 32'h0, '1, 257, 0, 0, 0, 1'b0, 1'b0, 1'b0, 1, "R8 stall 257");
      chk(aborts == 1, "R8 abort seen", aborts, 1);
      chk(!bus_rd && !bus_wr, "R8 bus idle after abort", {bus_rd, bus_wr}, 0);
      // R8 timeout on the write; R10 rerun after error
      run(32'h5555_6666, 32'h0000_0004, '1, 1, 1, 300, 0, 1'b0, 1'b0, 1'b0, 3, "R10 rerun/R8 write timeout");
      // R10 recovery after error
      run(32'h7777_8888, 32'h0000_0003, '1, 1, 2, 3, 4, 1'b0, 1'b0, 1'b1, 4, "R10 recover");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule